// File: doc/BRIEF.md
# Descriptor Prefetch Burst Scheduler

This block decides, one request at a time, which of several receive queues should have descriptors fetched from host memory next, and how many descriptors that fetch should ask for. For every queue it looks at how full the local prefetch buffer is, how many descriptors the host has posted that are not yet fetched, a QoS value, an enable bit and a permission to fetch a short burst. It issues a request (queue number plus burst length), holds it until the fetch engine reports completion, and then goes back to choosing.

A burst is worth issuing only when it is large enough. The smallest acceptable burst depends on whether the queue's buffer is below or at/above a fill threshold. Queues that are nearly empty can be promoted ahead of others, the queue served last can be kept in front with a force bit, and QoS priority can be replaced by strict round robin. Each queue also gets a registered almost-full flag for the application.

Top module: `desc_prefetch_sched`

## Requirements
- R1: While reset is asserted and after its release with no queue enabled, `reqValid` is 0 and every `almostFull` bit is 0.
- R2: A queue is a candidate only when its enable bit is 1 and its computed burst is non-zero and meets the minimum burst (see R4, R5); a disabled queue is never requested.
- R3: The burst length is the smaller of the posted-but-unfetched count and the free space `DEPTH - level` (0 when the level is at or above `DEPTH`).
- R4: The minimum burst is `minBurstLow` when the queue level is below `prefetchThr` and `minBurstHigh` when the level is at or above it; a burst below the minimum makes the queue ineligible. `minBurstLow` is meant to be programmed to 1.
- R5: A queue with its allow-short bit set is eligible with any non-zero burst, even one below the minimum.
- R6: With round robin not forced, the eligible queue with the highest QoS value wins.
- R7: Equal-priority candidates are taken in round-robin order: the search starts at the queue after the last completed request; after reset it starts at queue 0.
- R8: When `forceRoundRobin` is 1, QoS values are ignored and pure round robin (as in R7) applies.
- R9: When `promoteEn` is 1, a queue whose level is below `promoteThr` is promoted and beats every non-promoted queue regardless of QoS.
- R10: When `forcePromote` is 1 and at least one request has completed since reset, the queue of the last completed request is chosen whenever it is eligible, ahead of every other rule.
- R11: `reqValid` rises on the clock edge that follows an idle cycle with an eligible queue; queue and length are sampled at that edge and stay fixed until `reqDone` is seen high with `reqValid`; `reqValid` is 0 on the next cycle, which is an idle decision cycle.
- R12: `almostFull[q]` is 1 when queue q's level is at or above `almostFullThr`, updated one clock after the level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| qLevel | input | NQ*LVL_W (24) | Per-queue prefetch buffer fill level, queue q in bits [q*LVL_W +: LVL_W] |
| qPosted | input | NQ*POST_W (64) | Per-queue count of posted, not yet fetched descriptors |
| qQos | input | NQ*QOS_W (12) | Per-queue QoS value, larger wins |
| qEnable | input | NQ (4) | Per-queue fetch enable |
| qAllowShort | input | NQ (4) | Per-queue permission to fetch below the minimum burst |
| minBurstLow | input | 4 | Minimum burst while level is below `prefetchThr` |
| minBurstHigh | input | 4 | Minimum burst while level is at or above `prefetchThr` |
| prefetchThr | input | 8 | Level threshold selecting the minimum burst |
| promoteEn | input | 1 | Enables promotion of nearly empty queues |
| promoteThr | input | 8 | Level below which a queue is promoted |
| forcePromote | input | 1 | Keeps the last served queue in front while eligible |
| forceRoundRobin | input | 1 | Ignores QoS, pure round robin |
| almostFullThr | input | 8 | Level threshold for the almost-full flags |
| reqDone | input | 1 | Fetch engine has finished the current request |
| reqValid | output | 1 | A fetch request is pending |
| reqQueue | output | QID_W (2) | Queue of the pending request |
| reqLen | output | LVL_W (6) | Burst length of the pending request |
| almostFull | output | NQ (4) | Per-queue almost-full flags |

## Verification
A new request appears one edge after an idle cycle in which the inputs made a queue eligible, so the bench changes queue inputs only at a falling edge while no request is pending and reads the result at the following falling edge. A completion takes effect at the edge where `reqDone` is sampled, with `reqValid` low by the next falling edge and the round-robin pointer moved to the served queue before the next decision. The almost-full flags lag the level by one edge, and the bench checks the old value just after changing a level and the new value one cycle later. A behavioural model advanced on the same rising edges is compared against every output at each falling edge.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic capture;  // latch the chosen queue and burst as the new request
    logic retire;   // request finished: move the round-robin pointer
  } dpsStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } dpsState_e;

endpackage

// File: rtl/dps_queue_eval.sv
// Per-queue evaluation: burst size, minimum burst check and promotion.
module dps_queue_eval #(
  parameter int DEPTH  = 32,
  parameter int POST_W = 16,
  parameter int LVL_W  = 6
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [POST_W-1:0] posted,
  input  logic              enable,
  input  logic              allowShort,
  input  logic [3:0]        minLow,
  input  logic [3:0]        minHigh,
  input  logic [7:0]        prefThr,
  input  logic [7:0]        promoThr,
  input  logic              promoteEn,
  output logic              eligible,
  output logic              promoted,
  output logic [LVL_W-1:0]  burst
);

  localparam int TW = (LVL_W > 8) ? LVL_W : 8;
  localparam int PW = (POST_W > LVL_W) ? POST_W : LVL_W;

  logic [LVL_W-1:0] freeSpace;
  logic [PW-1:0]    freeWide;
  logic [PW-1:0]    postWide;
  logic [3:0]       minBurst;
  logic             belowPref;

  always_comb begin
    freeSpace = (level >= LVL_W'(DEPTH)) ? '0 : (LVL_W'(DEPTH) - level);
    freeWide  = PW'(freeSpace);
    postWide  = PW'(posted);
    burst     = (postWide < freeWide) ? LVL_W'(postWide) : freeSpace;
    belowPref = TW'(level) < TW'(prefThr);
    minBurst  = belowPref ? minLow : minHigh;
    eligible  = enable && (burst != '0) &&
                (allowShort || (TW'(minBurst) <= TW'(burst)));
    promoted  = promoteEn && (TW'(level) < TW'(promoThr));
  end

endmodule

// File: rtl/dps_datapath.sv
// Datapath: per-queue evaluation, arbitration and request registers.
module dps_datapath
  import dps_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int DEPTH  = 32,
  parameter int POST_W = 16,
  parameter int QOS_W  = 3,
  parameter int LVL_W  = 6,
  parameter int QID_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NQ*LVL_W-1:0] qLevel,
  input  logic [NQ*POST_W-1:0] qPosted,
  input  logic [NQ*QOS_W-1:0] qQos,
  input  logic [NQ-1:0]       qEnable,
  input  logic [NQ-1:0]       qAllowShort,
  input  logic [3:0]          minBurstLow,
  input  logic [3:0]          minBurstHigh,
  input  logic [7:0]          prefetchThr,
  input  logic                promoteEn,
  input  logic [7:0]          promoteThr,
  input  logic                forcePromote,
  input  logic                forceRoundRobin,
  input  logic [7:0]          almostFullThr,
  input  dpsStrobe_t          strobe,
  output logic                anyEligible,
  output logic [QID_W-1:0]    reqQueue,
  output logic [LVL_W-1:0]    reqLen,
  output logic [NQ-1:0]       almostFull
);

  localparam int SW = QOS_W + 1;
  localparam int TW = (LVL_W > 8) ? LVL_W : 8;

  logic [NQ-1:0]    elig;
  logic [NQ-1:0]    prom;
  logic [LVL_W-1:0] burst [NQ];
  logic [SW-1:0]    score [NQ];
  logic [NQ-1:0]    afNext;

  logic [QID_W-1:0] lastQ;
  logic             lastValid;
  logic             pickFound;
  logic [QID_W-1:0] pickQ;
  logic [SW-1:0]    pickScore;
  logic [QID_W-1:0] idx;

  for (genvar g = 0; g < NQ; g++) begin : gQueue
    dps_queue_eval #(
      .DEPTH (DEPTH),
      .POST_W(POST_W),
      .LVL_W (LVL_W)
    ) uEval (
      .level     (qLevel[g*LVL_W +: LVL_W]),
      .posted    (qPosted[g*POST_W +: POST_W]),
      .enable    (qEnable[g]),
      .allowShort(qAllowShort[g]),
      .minLow    (minBurstLow),
      .minHigh   (minBurstHigh),
      .prefThr   (prefetchThr),
      .promoThr  (promoteThr),
      .promoteEn (promoteEn),
      .eligible  (elig[g]),
      .promoted  (prom[g]),
      .burst     (burst[g])
    );

    // Priority key: promotion on top, QoS below unless round robin is forced.
    always_comb begin
      score[g] = {prom[g], forceRoundRobin ? {QOS_W{1'b0}} : qQos[g*QOS_W +: QOS_W]};
      afNext[g] = TW'(qLevel[g*LVL_W +: LVL_W]) >= TW'(almostFullThr);
    end
  end

  // Scan in round-robin order from the queue after the last served one;
  // only a strictly higher key replaces the current pick, so ties keep
  // the earliest queue in that order.
  always_comb begin
    pickFound = 1'b0;
    pickQ     = lastQ;
    pickScore = '0;
    idx       = '0;
    if (forcePromote && lastValid && elig[lastQ]) begin
      pickFound = 1'b1;
    end else begin
      for (int off = 1; off <= NQ; off++) begin
        idx = QID_W'((int'(lastQ) + off) % NQ);
        if (elig[idx] && (!pickFound || (score[idx] > pickScore))) begin
          pickFound = 1'b1;
          pickQ     = idx;
          pickScore = score[idx];
        end
      end
    end
  end

  assign anyEligible = pickFound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQueue   <= '0;
      reqLen     <= '0;
      lastQ      <= QID_W'(NQ - 1);
      lastValid  <= 1'b0;
      almostFull <= '0;
    end else begin
      almostFull <= afNext;
      if (strobe.capture) begin
        reqQueue <= pickQ;
        reqLen   <= burst[pickQ];
      end
      if (strobe.retire) begin
        lastQ     <= reqQueue;
        lastValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dps_control.sv
// Control: one request in flight, an idle decision cycle between requests.
module dps_control
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyEligible,
  input  logic       reqDone,
  output dpsStrobe_t strobe,
  output logic       reqValid
);

  dpsState_e state;
  dpsState_e stateNext;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && anyEligible;
    strobe.retire  = (state == ST_BUSY) && reqDone;
    stateNext      = state;
    if (strobe.capture) stateNext = ST_BUSY;
    if (strobe.retire)  stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqValid = (state == ST_BUSY);

endmodule

// File: rtl/desc_prefetch_sched.sv
module desc_prefetch_sched
  import dps_pkg::*;
#(
  parameter  int NQ     = 4,
  parameter  int DEPTH  = 32,
  parameter  int POST_W = 16,
  parameter  int QOS_W  = 3,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int QID_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NQ*LVL_W-1:0]  qLevel,
  input  logic [NQ*POST_W-1:0] qPosted,
  input  logic [NQ*QOS_W-1:0]  qQos,
  input  logic [NQ-1:0]        qEnable,
  input  logic [NQ-1:0]        qAllowShort,
  input  logic [3:0]           minBurstLow,
  input  logic [3:0]           minBurstHigh,
  input  logic [7:0]           prefetchThr,
  input  logic                 promoteEn,
  input  logic [7:0]           promoteThr,
  input  logic                 forcePromote,
  input  logic                 forceRoundRobin,
  input  logic [7:0]           almostFullThr,
  input  logic                 reqDone,
  output logic                 reqValid,
  output logic [QID_W-1:0]     reqQueue,
  output logic [LVL_W-1:0]     reqLen,
  output logic [NQ-1:0]        almostFull
);

  dpsStrobe_t strobe;
  logic       anyEligible;

  dps_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyEligible(anyEligible),
    .reqDone    (reqDone),
    .strobe     (strobe),
    .reqValid   (reqValid)
  );

  dps_datapath #(
    .NQ    (NQ),
    .DEPTH (DEPTH),
    .POST_W(POST_W),
    .QOS_W (QOS_W),
    .LVL_W (LVL_W),
    .QID_W (QID_W)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .qLevel         (qLevel),
    .qPosted        (qPosted),
    .qQos           (qQos),
    .qEnable        (qEnable),
    .qAllowShort    (qAllowShort),
    .minBurstLow    (minBurstLow),
    .minBurstHigh   (minBurstHigh),
    .prefetchThr    (prefetchThr),
    .promoteEn      (promoteEn),
    .promoteThr     (promoteThr),
    .forcePromote   (forcePromote),
    .forceRoundRobin(forceRoundRobin),
    .almostFullThr  (almostFullThr),
    .strobe         (strobe),
    .anyEligible    (anyEligible),
    .reqQueue       (reqQueue),
    .reqLen         (reqLen),
    .almostFull     (almostFull)
  );

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int NQ    = 4,
  parameter int DEPTH = 32,
  parameter int LVL_W = 6,
  parameter int QID_W = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [NQ*LVL_W-1:0] qLevel,
  input logic [NQ-1:0]       qEnable,
  input logic                reqDone,
  input logic                reqValid,
  input logic [QID_W-1:0]    reqQueue,
  input logic [LVL_W-1:0]    reqLen
);

  // Inputs as they were at the last rising edge (the capture edge).
  logic [NQ*LVL_W-1:0] prevLevel;
  logic [NQ-1:0]       prevEn;
  logic [LVL_W-1:0]    prevLvlSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
      prevEn    <= '0;
    end else begin
      prevLevel <= qLevel;
      prevEn    <= qEnable;
    end
  end

  assign prevLvlSel = prevLevel[reqQueue*LVL_W +: LVL_W];

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqDone |=> reqValid && $stable(reqQueue) && $stable(reqLen)); // R11

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqDone |=> !reqValid); // R11

  AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqLen != '0); // R2

  AST_BURST_FITS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> (int'(reqLen) <= DEPTH - int'(prevLvlSel))); // R3

  AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> prevEn[reqQueue]); // R2

endmodule

bind desc_prefetch_sched dps_checker #(
  .NQ   (NQ),
  .DEPTH(DEPTH),
  .LVL_W(LVL_W),
  .QID_W(QID_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .qLevel  (qLevel),
  .qEnable (qEnable),
  .reqDone (reqDone),
  .reqValid(reqValid),
  .reqQueue(reqQueue),
  .reqLen  (reqLen)
);

// File: tb/sim_desc_prefetch_sched.sv
`timescale 1ns/1ps
module sim_desc_prefetch_sched;

  localparam int NQ     = 4;
  localparam int DEPTH  = 32;
  localparam int POST_W = 16;
  localparam int QOS_W  = 3;
  localparam int LW     = $clog2(DEPTH + 1);
  localparam int QW     = $clog2(NQ);

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int bLvl [NQ];
  int bPost[NQ];
  int bQos [NQ];
  bit bEn  [NQ];
  bit bShort[NQ];

  logic [NQ*LW-1:0]     qLevel;
  logic [NQ*POST_W-1:0] qPosted;
  logic [NQ*QOS_W-1:0]  qQos;
  logic [NQ-1:0]        qEnable;
  logic [NQ-1:0]        qAllowShort;
  logic [3:0]           minLow, minHigh;
  logic [7:0]           prefThr, promoThr, afThr;
  logic                 promoEn, forceProm, forceRr;
  logic                 reqDone;
  logic                 reqValid;
  logic [QW-1:0]        reqQueue;
  logic [LW-1:0]        reqLen;
  logic [NQ-1:0]        almostFull;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      qLevel[q*LW +: LW]          = LW'(bLvl[q]);
      qPosted[q*POST_W +: POST_W] = POST_W'(bPost[q]);
      qQos[q*QOS_W +: QOS_W]      = QOS_W'(bQos[q]);
      qEnable[q]                  = bEn[q];
      qAllowShort[q]              = bShort[q];
    end
  end

  desc_prefetch_sched #(
    .NQ(NQ), .DEPTH(DEPTH), .POST_W(POST_W), .QOS_W(QOS_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .qLevel(qLevel), .qPosted(qPosted), .qQos(qQos),
    .qEnable(qEnable), .qAllowShort(qAllowShort), .minBurstLow(minLow),
    .minBurstHigh(minHigh), .prefetchThr(prefThr), .promoteEn(promoEn),
    .promoteThr(promoThr), .forcePromote(forceProm), .forceRoundRobin(forceRr),
    .almostFullThr(afThr), .reqDone(reqDone), .reqValid(reqValid),
    .reqQueue(reqQueue), .reqLen(reqLen), .almostFull(almostFull)
  );

  int    nCmp = 0;
  int    nBad = 0;
  int    cyc  = 0;
  string phase = "R1";

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mValid;
  int          mQ, mLen, mLast;
  bit          mLastValid;
  bit [NQ-1:0] mAf;

  function automatic void modelPick(output int pq, output int pl);
    bit elig[NQ];
    int len [NQ];
    int key [NQ];
    int best;
    pq = -1;
    pl = 0;
    for (int q = 0; q < NQ; q++) begin
      int room, minB;
      room   = (bLvl[q] >= DEPTH) ? 0 : DEPTH - bLvl[q];
      len[q] = (bPost[q] < room) ? bPost[q] : room;
      minB   = (bLvl[q] < int'(prefThr)) ? int'(minLow) : int'(minHigh);
      elig[q] = bEn[q] && len[q] > 0 && (bShort[q] || len[q] >= minB);
      key[q] = ((promoEn && bLvl[q] < int'(promoThr)) ? 100 : 0) + (forceRr ? 0 : bQos[q]);
    end
    if (forceProm && mLastValid && elig[mLast]) begin
      pq = mLast;
    end else begin
      best = -1;
      for (int off = 1; off <= NQ; off++) begin
        int i;
        i = (mLast + off) % NQ;
        if (elig[i] && key[i] > best) begin
          best = key[i];
          pq   = i;
        end
      end
    end
    if (pq >= 0) pl = len[pq];
  endfunction

  always @(posedge clk) begin
    int pq, pl;
    if (!rstN) begin
      mValid     <= 1'b0;
      mLast      <= NQ - 1;
      mLastValid <= 1'b0;
      mAf        <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) mAf[q] <= (bLvl[q] >= int'(afThr));
      if (mValid) begin
        if (reqDone) begin
          mValid     <= 1'b0;
          mLast      <= mQ;
          mLastValid <= 1'b1;
        end
      end else begin
        modelPick(pq, pl);
        if (pq >= 0) begin
          mValid <= 1'b1;
          mQ     <= pq;
          mLen   <= pl;
        end
      end
    end
  end

  // Compare every output against the model at each falling edge.
  always @(negedge clk) begin
    check(reqValid == mValid, phase, "model reqValid", int'(reqValid), int'(mValid));
    if (reqValid && mValid) begin
      check(int'(reqQueue) == mQ, phase, "model reqQueue", int'(reqQueue), mQ);
      check(int'(reqLen) == mLen, phase, "model reqLen", int'(reqLen), mLen);
    end
    check(almostFull == mAf, phase, "model almostFull", int'(almostFull), int'(mAf));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finishRun();
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic setQ(int q, int lvl, int post, int qos, bit en, bit sh);
    bLvl[q] = lvl; bPost[q] = post; bQos[q] = qos; bEn[q] = en; bShort[q] = sh;
  endtask

  task automatic expectNone(int n, string tag);
    phase = tag;
    repeat (n) begin
      @(negedge clk);
      check(reqValid == 1'b0, tag, "no request expected", int'(reqValid), 0);
    end
  endtask

  task automatic waitGrant(int eq, int el, string tag);
    int n = 0;
    int holdQ;
    phase = tag;
    while (!reqValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(reqValid == 1'b1, tag, "request raised", int'(reqValid), 1);
    check(int'(reqQueue) == eq, tag, "queue", int'(reqQueue), eq);
    check(int'(reqLen) == el, tag, "length", int'(reqLen), el);
    holdQ = int'(reqQueue);
    @(negedge clk);
    check(reqValid && int'(reqQueue) == holdQ && int'(reqLen) == el, "R11",
          "request held without done", int'(reqQueue), holdQ);
    reqDone = 1'b1;
    @(negedge clk);
    reqDone = 1'b0;
    check(reqValid == 1'b0, "R11", "released after done", int'(reqValid), 0);
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) setQ(q, 0, 0, 0, 1'b0, 1'b0);
    minLow = 4'd1; minHigh = 4'd4; prefThr = 8'd8; promoThr = 8'd4; afThr = 8'd24;
    promoEn = 1'b0; forceProm = 1'b0; forceRr = 1'b0; reqDone = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(reqValid == 1'b0, "R1", "reqValid in reset", int'(reqValid), 0);
    check(almostFull == '0, "R1", "almostFull in reset", int'(almostFull), 0);
    rstN = 1'b1;
    expectNone(2, "R1");

    // R2: nothing enabled, nothing requested; then one enabled queue
    setQ(2, 0, 20, 7, 1'b0, 1'b0);
    expectNone(4, "R2");
    setQ(2, 0, 0, 0, 1'b0, 1'b0);
    setQ(1, 0, 10, 0, 1'b1, 1'b0);
    waitGrant(1, 10, "R3");               // burst limited by posted count

    // R3: burst limited by free space (level 28 -> 4 free)
    setQ(1, 0, 0, 0, 1'b0, 1'b0);
    setQ(2, 28, 10, 0, 1'b1, 1'b0);
    waitGrant(2, 4, "R3");

    // R4: level at/above threshold needs 4; 3 available -> ineligible
    setQ(2, 0, 0, 0, 1'b0, 1'b0);
    setQ(0, 10, 3, 0, 1'b1, 1'b0);
    expectNone(4, "R4");
    setQ(0, 7, 3, 0, 1'b1, 1'b0);         // below threshold: minimum 1
    waitGrant(0, 3, "R4");

    // R5: short burst allowed above threshold
    setQ(0, 10, 3, 0, 1'b1, 1'b1);
    waitGrant(0, 3, "R5");

    // R6: QoS priority, disabled queue ignored
    setQ(0, 0, 5, 1, 1'b1, 1'b0);
    setQ(1, 0, 5, 5, 1'b1, 1'b0);
    setQ(2, 0, 5, 3, 1'b1, 1'b0);
    setQ(3, 0, 5, 7, 1'b0, 1'b0);
    waitGrant(1, 5, "R6");
    setQ(3, 0, 5, 7, 1'b1, 1'b0);
    waitGrant(3, 5, "R6");

    // R7: equal QoS rotates from the queue after the last served (3)
    for (int q = 0; q < NQ; q++) setQ(q, 0, 5, 2, 1'b1, 1'b0);
    waitGrant(0, 5, "R7");
    waitGrant(1, 5, "R7");
    waitGrant(2, 5, "R7");
    waitGrant(3, 5, "R7");

    // R8: forced round robin ignores QoS
    forceRr = 1'b1;
    setQ(0, 0, 5, 0, 1'b1, 1'b0);
    setQ(1, 0, 5, 7, 1'b1, 1'b0);
    setQ(2, 0, 5, 1, 1'b1, 1'b0);
    setQ(3, 0, 5, 7, 1'b1, 1'b0);
    waitGrant(0, 5, "R8");
    waitGrant(1, 5, "R8");
    waitGrant(2, 5, "R8");

    // R9: promotion of a nearly empty queue beats higher QoS
    forceRr = 1'b0;
    promoEn = 1'b1;
    setQ(0, 10, 5, 7, 1'b1, 1'b0);
    setQ(1, 0, 0, 0, 1'b0, 1'b0);
    setQ(2, 2, 5, 0, 1'b1, 1'b0);
    setQ(3, 0, 0, 0, 1'b0, 1'b0);
    waitGrant(2, 5, "R9");

    // R10: forced promotion keeps the last served queue while eligible
    forceProm = 1'b1;
    setQ(0, 2, 5, 7, 1'b1, 1'b0);
    waitGrant(2, 5, "R10");
    setQ(2, 2, 5, 0, 1'b0, 1'b0);
    waitGrant(0, 5, "R10");

    // R12: almost-full flag follows the level one clock later
    forceProm = 1'b0;
    promoEn   = 1'b0;
    for (int q = 0; q < NQ; q++) setQ(q, 0, 0, 0, 1'b0, 1'b0);
    phase = "R12";
    @(negedge clk);
    bLvl[1] = 24;
    #1;
    check(almostFull[1] == 1'b0, "R12", "flag before edge", int'(almostFull[1]), 0);
    @(negedge clk);
    check(almostFull[1] == 1'b1, "R12", "flag at threshold", int'(almostFull[1]), 1);
    bLvl[1] = 23;
    @(negedge clk);
    check(almostFull[1] == 1'b0, "R12", "flag below threshold", int'(almostFull[1]), 0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule